// File: doc/BRIEF.md
# Phase-Adjustable Sample Clock Divider

This block turns a fast master clock (nominally 38.88 MHz) into two strobes. The first is a reference strobe at one quarter of the master rate (9.72 MHz). The second is a sample strobe, produced by counting reference strobes. A sample period lasts 243 reference strobes in analog mode (40 kHz) and 200 reference strobes in digital mode (48.6 kHz). Each strobe is a single master-clock cycle wide. The block does not generate separate clocks; every register runs on the master clock.

To line receiver sampling up with the base station, a controller can ask the block to slip the sample phase by a signed number of sample periods. In each slipped period, one of two prescaler stages changes its ratio for one cycle of its own.
- The reference stage gives one master cycle of change: it divides by 3 instead of 4 for an advance, or by 5 for a retard.
- The tail segment of the sample count gives a coarser change. It is nominally 18 reference strobes long and can be switched to 17, 19 or 20.

After the last slipped period the block returns to nominal ratios and pulses a completion flag.

The controller is an enumerated state machine with three states:
- IDLE: no adjustment is in progress, and a request is accepted.
- ARMED: a request has been taken, and the block is waiting for the next sample strobe.
- SLIP: the current sample period is being altered.

It has these transitions:
- ACCEPT: IDLE to ARMED, on a request.
- START: ARMED to SLIP, at a sample strobe while periods remain.
- CONTINUE: SLIP to SLIP, at a sample strobe while periods remain.
- FINISH: ARMED or SLIP to IDLE, at a sample strobe once no periods remain. FINISH pulses the completion flag.

Top module: `slip_sample_divider`

## Requirements
- R1: With no adjustment in progress, `ref_tick_o` pulses once every 4 master cycles.
- R2: After reset the block is in analog mode, and both `sample_tick_o` and `adj_done_o` are low. In analog mode (`mode_dig_i` = 0) with no adjustment, successive `sample_tick_o` pulses are 972 master cycles apart.
- R3: In digital mode (`mode_dig_i` = 1) with no adjustment, successive `sample_tick_o` pulses are 800 master cycles apart.
- R4: `mode_dig_i` is sampled only in the cycle that ends a sample period. A change made partway through a period leaves that period at its old length, and the next period takes the new length.
- R5: Step code 0 (fine) changes the first reference interval of each slipped period. A negative count makes that interval 3 master cycles, so the period is 1 cycle shorter. A positive count makes it 5 master cycles, so the period is 1 cycle longer. Step code 3 behaves exactly like code 0.
- R6: Step code 1 (coarse) changes the tail segment of each slipped period. A negative count makes the segment 17 reference strobes long, so the period is 4 master cycles shorter. A positive count makes it 19, so the period is 4 master cycles longer.
- R7: Step code 2 (wide) makes the tail segment 17 reference strobes long for a negative count (period 4 master cycles shorter). For a positive count it makes the segment 20 long (period 8 master cycles longer).
- R8: Suppose `adj_req_i` is high for one cycle while the controller is idle. The period in progress is then left unchanged. The next |count| periods are slipped. `adj_done_o` pulses together with the `sample_tick_o` that ends the last slipped period. A count of 0 slips no period and pulses `adj_done_o` with the next `sample_tick_o`.
- R9: A request that arrives while an earlier adjustment is pending or active is ignored. It slips no extra period and gives no extra `adj_done_o` pulse.
- R10: Every `sample_tick_o` pulse falls in the same cycle as a `ref_tick_o` pulse. `adj_done_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_dig_i | input | 1 | 1 selects digital mode (200 reference strobes per period), 0 selects analog mode (243) |
| adj_req_i | input | 1 | One-cycle request to start a phase adjustment |
| adj_count_i | input | CNT_W (8) | Signed number of periods to slip; negative advances, positive retards |
| adj_step_i | input | 2 | Slip size: 0 or 3 fine, 1 coarse, 2 wide |
| ref_tick_o | output | 1 | Reference-rate strobe (master divided by about 4) |
| sample_tick_o | output | 1 | Sample-rate strobe |
| adj_done_o | output | 1 | One-cycle pulse when the requested adjustment has completed |

## Verification
The assertions check strobe spacing against the widest slip the step codes allow. They therefore assume that `adj_step_i` and the sign of `adj_count_i` are meaningful only in the cycle where `adj_req_i` is high. They also assume that mode changes happen only through `mode_dig_i`, so that no period is longer than an analog period retarded by the wide step. The stimulus keeps to these assumptions as follows:
- It drives every request as a one-cycle pulse just after a sample strobe, holding count and step stable for that cycle.
- It changes mode only between requests.
- It sweeps every step code, both signs and both modes, and computes each expected period length arithmetically.

// File: rtl/sd_pkg.sv
package sd_pkg;

    typedef enum logic [1:0] {
        STEP_FINE   = 2'd0,
        STEP_COARSE = 2'd1,
        STEP_WIDE   = 2'd2,
        STEP_ALT    = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SLIP  = 2'd2
    } slip_state_e;

    function automatic logic step_is_fine(step_e s);
        return (s == STEP_FINE) || (s == STEP_ALT);
    endfunction

endpackage

// File: rtl/sd_ref_stage.sv
module sd_ref_stage #(
    parameter int REF_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic first_ref_i,
    input  logic fine_slip_i,
    input  logic slip_adv_i,
    output logic ref_end_o,
    output logic ref_tick_o
);
    localparam int MW = $clog2(REF_DIV + 2);
    localparam logic [MW-1:0] LAST_NOM   = MW'(REF_DIV - 1);
    localparam logic [MW-1:0] LAST_SHORT = MW'(REF_DIV - 2);
    localparam logic [MW-1:0] LAST_LONG  = MW'(REF_DIV);

    logic [MW-1:0] mcnt_q;
    logic [MW-1:0] last_idx;

    // ratio select: alternate ratio only on the first reference interval of a fine-slipped period
    always_comb begin
        if (fine_slip_i && first_ref_i)
            last_idx = slip_adv_i ? LAST_SHORT : LAST_LONG;
        else
            last_idx = LAST_NOM;
    end

    assign ref_end_o = (mcnt_q == last_idx);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mcnt_q     <= '0;
            ref_tick_o <= 1'b0;
        end else begin
            mcnt_q     <= ref_end_o ? '0 : mcnt_q + 1'b1;
            ref_tick_o <= ref_end_o;
        end
    end
endmodule

// File: rtl/sd_period_stage.sv
module sd_period_stage
    import sd_pkg::*;
#(
    parameter int ANA_DIV = 243,
    parameter int DIG_DIV = 200,
    parameter int SEG_NOM = 18
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  mode_dig_i,
    input  logic  ref_end_i,
    input  logic  slip_on_i,
    input  logic  slip_adv_i,
    input  step_e slip_kind_i,
    output logic  first_ref_o,
    output logic  per_end_o,
    output logic  sample_tick_o
);
    localparam int RW = $clog2(ANA_DIV + 3);
    localparam logic [RW-1:0] ANA_BODY = RW'(ANA_DIV - SEG_NOM);
    localparam logic [RW-1:0] DIG_BODY = RW'(DIG_DIV - SEG_NOM);
    localparam logic [RW-1:0] SEG_SHORT = RW'(SEG_NOM - 1);
    localparam logic [RW-1:0] SEG_MID   = RW'(SEG_NOM);
    localparam logic [RW-1:0] SEG_LONG  = RW'(SEG_NOM + 1);
    localparam logic [RW-1:0] SEG_WIDE  = RW'(SEG_NOM + 2);

    logic [RW-1:0] rcnt_q;
    logic          mode_q;
    logic [RW-1:0] seg_len;
    logic [RW-1:0] body_len;
    logic [RW-1:0] last_ref;

    // tail segment: the coarse adjust stage
    always_comb begin
        seg_len = SEG_MID;
        if (slip_on_i && !step_is_fine(slip_kind_i)) begin
            if (slip_adv_i)
                seg_len = SEG_SHORT;
            else if (slip_kind_i == STEP_WIDE)
                seg_len = SEG_WIDE;
            else
                seg_len = SEG_LONG;
        end
    end

    assign body_len    = mode_q ? DIG_BODY : ANA_BODY;
    assign last_ref    = body_len + seg_len - 1'b1;
    assign first_ref_o = (rcnt_q == '0);
    assign per_end_o   = ref_end_i && (rcnt_q == last_ref);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rcnt_q        <= '0;
            mode_q        <= 1'b0;
            sample_tick_o <= 1'b0;
        end else begin
            sample_tick_o <= per_end_o;
            if (ref_end_i)
                rcnt_q <= per_end_o ? '0 : rcnt_q + 1'b1;
            if (per_end_o)
                mode_q <= mode_dig_i;
        end
    end
endmodule

// File: rtl/sd_slip_ctrl.sv
module sd_slip_ctrl
    import sd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             adj_req_i,
    input  logic [CNT_W-1:0] adj_count_i,
    input  logic [1:0]       adj_step_i,
    input  logic             per_end_i,
    output logic             slip_on_o,
    output logic             slip_adv_o,
    output step_e            slip_kind_o,
    output logic             done_o
);
    slip_state_e      st_q, st_d;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] mag;
    logic             accept;
    logic             boundary;

    assign mag      = adj_count_i[CNT_W-1] ? (~adj_count_i + 1'b1) : adj_count_i;
    assign accept   = (st_q == ST_IDLE) && adj_req_i;
    assign boundary = (st_q != ST_IDLE) && per_end_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (adj_req_i) st_d = ST_ARMED;             // ACCEPT
            ST_ARMED,
            ST_SLIP:  if (per_end_i)
                          st_d = (rem_q != '0) ? ST_SLIP : ST_IDLE; // START/CONTINUE or FINISH
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register and remaining-period count
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_IDLE;
            rem_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept)
                rem_q <= mag;
            else if (boundary && rem_q != '0)
                rem_q <= rem_q - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slip_on_o   <= 1'b0;
            slip_adv_o  <= 1'b0;
            slip_kind_o <= STEP_FINE;
            done_o      <= 1'b0;
        end else begin
            done_o <= boundary && (rem_q == '0);
            if (per_end_i)
                slip_on_o <= boundary && (rem_q != '0);
            if (accept) begin
                slip_adv_o  <= adj_count_i[CNT_W-1];
                slip_kind_o <= step_e'(adj_step_i);
            end
        end
    end
endmodule

// File: rtl/slip_sample_divider.sv
module slip_sample_divider
    import sd_pkg::*;
#(
    parameter int REF_DIV = 4,
    parameter int ANA_DIV = 243,
    parameter int DIG_DIV = 200,
    parameter int SEG_NOM = 18,
    parameter int CNT_W   = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_dig_i,
    input  logic             adj_req_i,
    input  logic [CNT_W-1:0] adj_count_i,
    input  logic [1:0]       adj_step_i,
    output logic             ref_tick_o,
    output logic             sample_tick_o,
    output logic             adj_done_o
);
    logic  ref_end;
    logic  per_end;
    logic  first_ref;
    logic  slip_on;
    logic  slip_adv;
    step_e slip_kind;
    logic  fine_slip;

    assign fine_slip = slip_on && step_is_fine(slip_kind);

    sd_ref_stage #(.REF_DIV(REF_DIV)) u_ref (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .first_ref_i (first_ref),
        .fine_slip_i (fine_slip),
        .slip_adv_i  (slip_adv),
        .ref_end_o   (ref_end),
        .ref_tick_o  (ref_tick_o)
    );

    sd_period_stage #(
        .ANA_DIV (ANA_DIV),
        .DIG_DIV (DIG_DIV),
        .SEG_NOM (SEG_NOM)
    ) u_per (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .mode_dig_i    (mode_dig_i),
        .ref_end_i     (ref_end),
        .slip_on_i     (slip_on),
        .slip_adv_i    (slip_adv),
        .slip_kind_i   (slip_kind),
        .first_ref_o   (first_ref),
        .per_end_o     (per_end),
        .sample_tick_o (sample_tick_o)
    );

    sd_slip_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .adj_req_i   (adj_req_i),
        .adj_count_i (adj_count_i),
        .adj_step_i  (adj_step_i),
        .per_end_i   (per_end),
        .slip_on_o   (slip_on),
        .slip_adv_o  (slip_adv),
        .slip_kind_o (slip_kind),
        .done_o      (adj_done_o)
    );
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
    parameter int REF_DIV = 4,
    parameter int ANA_DIV = 243,
    parameter int DIG_DIV = 200
) (
    input logic clk_i,
    input logic rst_ni,
    input logic ref_tick_o,
    input logic sample_tick_o,
    input logic adj_done_o
);
    localparam int GAP_MIN = REF_DIV * (DIG_DIV - 1);
    localparam int GAP_MAX = REF_DIV * (ANA_DIV + 2);

    logic [15:0] ref_gap, smp_gap;
    logic        ref_seen, smp_seen;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ref_gap  <= '0;
            smp_gap  <= '0;
            ref_seen <= 1'b0;
            smp_seen <= 1'b0;
        end else begin
            ref_gap <= ref_tick_o ? 16'd1 : ref_gap + 16'd1;
            smp_gap <= sample_tick_o ? 16'd1 : smp_gap + 16'd1;
            if (ref_tick_o)    ref_seen <= 1'b1;
            if (sample_tick_o) smp_seen <= 1'b1;
        end
    end

    assert_ref_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_tick_o && ref_seen) |-> (int'(ref_gap) >= REF_DIV - 1 && int'(ref_gap) <= REF_DIV + 1));

    assert_sample_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_tick_o && smp_seen) |-> (int'(smp_gap) >= GAP_MIN && int'(smp_gap) <= GAP_MAX));

    assert_done_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adj_done_o |-> sample_tick_o);

    assert_tick_on_ref_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_tick_o |-> ref_tick_o);

    assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adj_done_o |=> !adj_done_o);
endmodule

bind slip_sample_divider sd_checker #(
    .REF_DIV (REF_DIV),
    .ANA_DIV (ANA_DIV),
    .DIG_DIV (DIG_DIV)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ref_tick_o    (ref_tick_o),
    .sample_tick_o (sample_tick_o),
    .adj_done_o    (adj_done_o)
);

// File: tb/sim_slip_sample_divider.sv
module sim_slip_sample_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_dig = 1'b0;
    logic       adj_req = 1'b0;
    logic [7:0] adj_count = '0;
    logic [1:0] adj_step = '0;
    logic       ref_tick, sample_tick, adj_done;

    int cyc = 0;
    int last_tick = 0;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    slip_sample_divider u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .mode_dig_i    (mode_dig),
        .adj_req_i     (adj_req),
        .adj_count_i   (adj_count),
        .adj_step_i    (adj_step),
        .ref_tick_o    (ref_tick),
        .sample_tick_o (sample_tick),
        .adj_done_o    (adj_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int gap, output bit dn);
        do @(negedge clk); while (!sample_tick);
        gap = cyc - last_tick;
        last_tick = cyc;
        dn = adj_done;
    endtask

    task automatic request(input int cnt, input int step);
        adj_req   = 1'b1;
        adj_count = 8'(cnt);
        adj_step  = 2'(step);
        @(negedge clk);
        adj_req   = 1'b0;
    endtask

    function automatic int nominal(input int m);
        return m ? 800 : 972;
    endfunction

    function automatic int slipped(input int m, input int step, input bit adv);
        int p = nominal(m);
        case (step)
            1:       return adv ? p - 4 : p + 4;
            2:       return adv ? p - 4 : p + 8;
            default: return adv ? p - 1 : p + 1;
        endcase
    endfunction

    function automatic string step_req(input int step);
        case (step)
            1:       return "R6";
            2:       return "R7";
            default: return "R5";
        endcase
    endfunction

    initial begin
        int g;
        bit d;
        int prev;
        repeat (3) @(negedge clk);
        chk(sample_tick == 0 && adj_done == 0 && ref_tick == 0, "R2 reset outputs", int'(sample_tick), 0);
        rst_n = 1'b1;

        // R1: reference strobe spacing
        do @(negedge clk); while (!ref_tick);
        prev = cyc;
        for (int i = 0; i < 3; i++) begin
            do @(negedge clk); while (!ref_tick);
            chk(cyc - prev == 4, "R1 ref spacing", cyc - prev, 4);
            prev = cyc;
        end

        // R2: analog default after reset
        wait_tick(g, d);
        chk(sample_tick && ref_tick, "R10 tick with ref", int'(ref_tick), 1);
        wait_tick(g, d);
        chk(g == 972, "R2 analog period", g, 972);

        // sweep: modes, steps, signs
        for (int m = 0; m < 2; m++) begin
            mode_dig = 1'(m);
            wait_tick(g, d);
            wait_tick(g, d);
            chk(g == nominal(m), m ? "R3 digital period" : "R2 analog period", g, nominal(m));
            for (int s = 0; s < 4; s++) begin
                for (int a = 0; a < 2; a++) begin
                    request(a ? -2 : 2, s);
                    wait_tick(g, d);
                    chk(g == nominal(m) && !d, "R8 current period untouched", g, nominal(m));
                    wait_tick(g, d);
                    chk(g == slipped(m, s, 1'(a)), step_req(s), g, slipped(m, s, 1'(a)));
                    chk(!d, "R8 no early done", int'(d), 0);
                    wait_tick(g, d);
                    chk(g == slipped(m, s, 1'(a)), step_req(s), g, slipped(m, s, 1'(a)));
                    chk(d, "R8 done on last slipped tick", int'(d), 1);
                    wait_tick(g, d);
                    chk(g == nominal(m) && !d, "R8 back to nominal", g, nominal(m));
                end
            end
        end

        // R8: zero count
        request(0, 0);
        wait_tick(g, d);
        chk(g == 800 && d, "R8 zero count done", int'(d), 1);
        wait_tick(g, d);
        chk(g == 800 && !d, "R8 zero count no slip", g, 800);

        // R9: request while active is ignored
        request(2, 0);
        wait_tick(g, d);
        request(5, 1);
        wait_tick(g, d);
        chk(g == 801, "R9 first slip kept", g, 801);
        wait_tick(g, d);
        chk(g == 801 && d, "R9 second slip and done", g, 801);
        wait_tick(g, d);
        chk(g == 800 && !d, "R9 extra request ignored", g, 800);

        // R4: mid-period mode change
        repeat (100) @(negedge clk);
        mode_dig = 1'b0;
        wait_tick(g, d);
        chk(g == 800, "R4 old mode kept", g, 800);
        wait_tick(g, d);
        chk(g == 972, "R4 new mode applied", g, 972);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule